// File: doc/BRIEF.md
# Bus-Master IDE Register File

This block holds the DMA control registers that software uses to run bus-master transfers on a two-channel disk controller. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor table pointer. The block also keeps track of which of the channel's two drives is currently selected. A write that sets the command's start bit sends a one-cycle start pulse to an external DMA engine, and a write that clears it sends a stop pulse. The engine reports its active state, its completion interrupts and its errors back into the status register. Software acknowledges the interrupt and error flags by writing ones to them.

All accesses arrive on one access port. A space select picks either the bus-master register window or the per-channel drive command block. The only drive command block register kept here is the drive-select register. When the bus-master enable input is low, writes into the bus-master window are dropped. A write with an unsupported width, or a start request aimed at a drive that is absent, is refused and raises a one-cycle error pulse.

Top module: `ide_bm_regs`

## Requirements
- R1: After reset, every command, status, pointer and drive-select value reads as zero. The outputs dmaStart, dmaStop, dmaDir, devSel and accErr are all low.
- R2: A bus-master write to offset 0 (command) is taken only at size code 0 (one byte). Any other size leaves the command register unchanged and raises accErr in the following cycle. The command byte uses bit 0 as start and bit 3 as direction.
- R3: A command write that changes start from 0 to 1 produces a one-cycle dmaStart on that channel in the following cycle. A write that changes it from 1 to 0 produces a one-cycle dmaStop. A write that leaves start unchanged produces no pulse.
- R4: The selected drive of channel c is present when devPresent[2c+devSel[c]] is high. A start request while the selected drive is absent leaves start at 0, produces no dmaStart and raises accErr. The direction bit of that write is still taken.
- R5: A bus-master write to offset 2 (status) is taken only at size code 0. Other sizes raise accErr. Status bit 0 (active) always reads the channel's dmaActive input as sampled at the previous clock edge, and software writes never change it.
- R6: Status bit 2 (interrupt) is set by a dmaIntEv pulse. It is cleared by a status write with bit 2 set, and it keeps its value on every other write. An event in the same cycle as a clearing write leaves the bit set.
- R7: Status bit 1 (error) is set by a dmaErrEv pulse. It is cleared by a status write with bit 1 set, and it keeps its value on every other write. An event in the same cycle as a clearing write leaves the bit set.
- R8: A bus-master write to offset 4 (pointer) is taken only at size code 2 (four bytes). Bits 1:0 of the pointer read as zero. Any other size leaves the pointer unchanged and raises accErr.
- R9: A drive command block write to offset 6 selects drive 1 when data bit 4 is 1 and drive 0 when it is 0. Sizes 0, 1 and 2 (one, two, four bytes) are accepted there. Size code 3 raises accErr and changes nothing. A read of offset 6 returns the selection in bit 4.
- R10: While busMasterEn is low, writes to the bus-master window change no register, produce no pulse and raise no error. Drive command block writes are still taken.
- R11: Address bit 3 picks the channel and bits 2:0 pick the register. A write to one channel never changes the other channel. rdData shows the addressed register combinationally, and unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMasterEn | input | 1 | Bus-master enable; low drops bus-master window writes |
| accValid | input | 1 | Access present this cycle |
| accWrite | input | 1 | 1 for write, 0 for read |
| accSpace | input | 1 | 0 selects the bus-master window, 1 the drive command block |
| accAddr | input | 4 | Bit 3 channel, bits 2:0 register offset |
| accSize | input | 2 | Width code: 0 one byte, 1 two, 2 four, 3 eight |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Addressed register value, zero-extended |
| accErr | output | 1 | One-cycle pulse for a refused write |
| devPresent | input | 4 | Drive present flags, bit 2c+d for channel c drive d |
| dmaActive | input | 2 | Per-channel engine busy level |
| dmaIntEv | input | 2 | Per-channel completion interrupt event |
| dmaErrEv | input | 2 | Per-channel engine error event |
| dmaStart | output | 2 | Per-channel start pulse to the engine |
| dmaStop | output | 2 | Per-channel stop pulse to the engine |
| dmaDir | output | 2 | Per-channel command direction bit |
| devSel | output | 2 | Per-channel selected drive |

## Verification
The checker tests the following on every cycle. Start pulses only follow a rising start bit and a present selected drive, and stop pulses only follow a falling one. The active flag tracks the engine input one cycle late. Interrupt and error events always leave their flags set. A low bus-master enable freezes the pointer and suppresses pulses. The bench's scenarios are needed for the rest: the refusal of each wrong access width, write-one-to-clear against a simultaneous event, the masking of the pointer's low bits, drive selection and channel isolation. These are compared against a behavioural model cycle by cycle, together with a random access phase.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;
  localparam logic [2:0] OFS_SEL  = 3'd6;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACT_BIT    = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_INT_BIT    = 2;
  localparam int SEL_DEV_BIT   = 4;

  // per-channel write strobes from control to datapath
  typedef struct packed {
    logic cmdWr;
    logic statWr;
    logic ptrWr;
    logic selWr;
  } chStrobe_t;

endpackage

// File: rtl/ide_bm_ctrl.sv
module ide_bm_ctrl
  import ide_bm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = CH_W + 3
) (
  input  logic                     busMasterEn,
  input  logic                     accValid,
  input  logic                     accWrite,
  input  logic                     accSpace,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic [1:0]               accSize,
  output chStrobe_t [NUM_CH-1:0]   strobe,
  output logic                     sizeErr
);

  accSize_e     sz;
  logic [CH_W-1:0] ch;
  logic [2:0]   ofs;
  logic         wrAny, bmWr, tfWr;
  logic         cmdHit, statHit, ptrHit, selHit;
  logic         isByte, isWord, isWide;

  assign sz     = accSize_e'(accSize);
  assign ch     = accAddr[ADDR_W-1:3];
  assign ofs    = accAddr[2:0];
  assign wrAny  = accValid && accWrite;
  assign bmWr   = wrAny && !accSpace && busMasterEn;
  assign tfWr   = wrAny && accSpace;

  assign isByte = (sz == SZ_BYTE);
  assign isWord = (sz == SZ_WORD);
  assign isWide = (sz == SZ_DWORD);

  assign cmdHit  = bmWr && (ofs == OFS_CMD);
  assign statHit = bmWr && (ofs == OFS_STAT);
  assign ptrHit  = bmWr && (ofs == OFS_PTR);
  assign selHit  = tfWr && (ofs == OFS_SEL);

  assign sizeErr = (cmdHit  && !isByte) ||
                   (statHit && !isByte) ||
                   (ptrHit  && !isWord) ||
                   (tfWr    &&  isWide);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hitCh;
    assign hitCh = (ch == CH_W'(c));
    always_comb begin
      strobe[c].cmdWr  = hitCh && cmdHit  && isByte;
      strobe[c].statWr = hitCh && statHit && isByte;
      strobe[c].ptrWr  = hitCh && ptrHit  && isWord;
      strobe[c].selWr  = hitCh && selHit  && !isWide;
    end
  end

endmodule

// File: rtl/ide_bm_dpath.sv
module ide_bm_dpath
  import ide_bm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = CH_W + 3,
  parameter int PTR_W  = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  chStrobe_t [NUM_CH-1:0]       strobe,
  input  logic                         sizeErr,
  input  logic [PTR_W-1:0]             wrData,
  input  logic                         accSpace,
  input  logic [ADDR_W-1:0]            accAddr,
  input  logic [2*NUM_CH-1:0]          devPresent,
  input  logic [NUM_CH-1:0]            dmaActive,
  input  logic [NUM_CH-1:0]            dmaIntEv,
  input  logic [NUM_CH-1:0]            dmaErrEv,
  output logic [PTR_W-1:0]             rdData,
  output logic                         accErr,
  output logic [NUM_CH-1:0]            dmaStart,
  output logic [NUM_CH-1:0]            dmaStop,
  output logic [NUM_CH-1:0]            dmaDir,
  output logic [NUM_CH-1:0]            devSel,
  output logic [NUM_CH-1:0]            startState,
  output logic [NUM_CH-1:0]            intState,
  output logic [NUM_CH-1:0]            errState,
  output logic [NUM_CH-1:0]            actState,
  output logic [NUM_CH-1:0][PTR_W-1:0] ptrState
);

  logic [NUM_CH-1:0] noDev;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             startQ, dirQ, actQ, intQ, errQ, selQ;
    logic             startP, stopP;
    logic [PTR_W-1:0] ptrQ;
    logic [1:0]       pair;
    logic             selPresent, wantStart, startReq;

    assign pair       = devPresent[2*c +: 2];
    assign selPresent = selQ ? pair[1] : pair[0];
    assign wantStart  = wrData[CMD_START_BIT];
    assign startReq   = strobe[c].cmdWr && wantStart && !startQ;
    assign noDev[c]   = startReq && !selPresent;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startQ <= 1'b0;
        dirQ   <= 1'b0;
        actQ   <= 1'b0;
        intQ   <= 1'b0;
        errQ   <= 1'b0;
        selQ   <= 1'b0;
        startP <= 1'b0;
        stopP  <= 1'b0;
        ptrQ   <= '0;
      end else begin
        startP <= 1'b0;
        stopP  <= 1'b0;
        actQ   <= dmaActive[c];
        if (strobe[c].cmdWr) begin
          dirQ <= wrData[CMD_DIR_BIT];
          if (startReq && selPresent) begin
            startQ <= 1'b1;
            startP <= 1'b1;
          end else if (!wantStart && startQ) begin
            startQ <= 1'b0;
            stopP  <= 1'b1;
          end
        end
        // events take priority over a clearing write
        if (dmaIntEv[c]) begin
          intQ <= 1'b1;
        end else if (strobe[c].statWr && wrData[ST_INT_BIT]) begin
          intQ <= 1'b0;
        end
        if (dmaErrEv[c]) begin
          errQ <= 1'b1;
        end else if (strobe[c].statWr && wrData[ST_ERR_BIT]) begin
          errQ <= 1'b0;
        end
        if (strobe[c].ptrWr) begin
          ptrQ <= {wrData[PTR_W-1:2], 2'b00};
        end
        if (strobe[c].selWr) begin
          selQ <= wrData[SEL_DEV_BIT];
        end
      end
    end

    assign startState[c] = startQ;
    assign intState[c]   = intQ;
    assign errState[c]   = errQ;
    assign actState[c]   = actQ;
    assign ptrState[c]   = ptrQ;
    assign dmaStart[c]   = startP;
    assign dmaStop[c]    = stopP;
    assign dmaDir[c]     = dirQ;
    assign devSel[c]     = selQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accErr <= 1'b0;
    end else begin
      accErr <= sizeErr || (|noDev);
    end
  end

  logic [CH_W-1:0] rdCh;
  logic [2:0]      rdOfs;
  assign rdCh  = accAddr[ADDR_W-1:3];
  assign rdOfs = accAddr[2:0];

  always_comb begin
    rdData = '0;
    if (!accSpace) begin
      case (rdOfs)
        OFS_CMD: begin
          rdData[CMD_START_BIT] = startState[rdCh];
          rdData[CMD_DIR_BIT]   = dmaDir[rdCh];
        end
        OFS_STAT: begin
          rdData[ST_ACT_BIT] = actState[rdCh];
          rdData[ST_ERR_BIT] = errState[rdCh];
          rdData[ST_INT_BIT] = intState[rdCh];
        end
        OFS_PTR: rdData = ptrState[rdCh];
        default: rdData = '0;
      endcase
    end else if (rdOfs == OFS_SEL) begin
      rdData[SEL_DEV_BIT] = devSel[rdCh];
    end
  end

endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int PTR_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3,
  localparam int DEV_N  = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMasterEn,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accSpace,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [PTR_W-1:0]  wrData,
  output logic [PTR_W-1:0]  rdData,
  output logic              accErr,
  input  logic [DEV_N-1:0]  devPresent,
  input  logic [NUM_CH-1:0] dmaActive,
  input  logic [NUM_CH-1:0] dmaIntEv,
  input  logic [NUM_CH-1:0] dmaErrEv,
  output logic [NUM_CH-1:0] dmaStart,
  output logic [NUM_CH-1:0] dmaStop,
  output logic [NUM_CH-1:0] dmaDir,
  output logic [NUM_CH-1:0] devSel
);

  chStrobe_t [NUM_CH-1:0]       strobe;
  logic                         sizeErr;
  logic [NUM_CH-1:0]            startState, intState, errState, actState;
  logic [NUM_CH-1:0][PTR_W-1:0] ptrState;

  ide_bm_ctrl #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busMasterEn(busMasterEn),
    .accValid   (accValid),
    .accWrite   (accWrite),
    .accSpace   (accSpace),
    .accAddr    (accAddr),
    .accSize    (accSize),
    .strobe     (strobe),
    .sizeErr    (sizeErr)
  );

  ide_bm_dpath #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .ADDR_W(ADDR_W),
    .PTR_W (PTR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sizeErr   (sizeErr),
    .wrData    (wrData),
    .accSpace  (accSpace),
    .accAddr   (accAddr),
    .devPresent(devPresent),
    .dmaActive (dmaActive),
    .dmaIntEv  (dmaIntEv),
    .dmaErrEv  (dmaErrEv),
    .rdData    (rdData),
    .accErr    (accErr),
    .dmaStart  (dmaStart),
    .dmaStop   (dmaStop),
    .dmaDir    (dmaDir),
    .devSel    (devSel),
    .startState(startState),
    .intState  (intState),
    .errState  (errState),
    .actState  (actState),
    .ptrState  (ptrState)
  );

endmodule

// File: rtl/ide_bm_regs_chk.sv
module ide_bm_regs_chk #(
  parameter int NUM_CH = 2,
  parameter int PTR_W  = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         busMasterEn,
  input logic [2*NUM_CH-1:0]          devPresent,
  input logic [NUM_CH-1:0]            devSel,
  input logic [NUM_CH-1:0]            dmaActive,
  input logic [NUM_CH-1:0]            dmaIntEv,
  input logic [NUM_CH-1:0]            dmaErrEv,
  input logic [NUM_CH-1:0]            dmaStart,
  input logic [NUM_CH-1:0]            dmaStop,
  input logic [NUM_CH-1:0]            startState,
  input logic [NUM_CH-1:0]            intState,
  input logic [NUM_CH-1:0]            errState,
  input logic [NUM_CH-1:0]            actState,
  input logic [NUM_CH-1:0][PTR_W-1:0] ptrState
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic selPresent;
    assign selPresent = devSel[c] ? devPresent[2*c+1] : devPresent[2*c];

    a_r3_start_on_rise: assert property (@(posedge clk) disable iff (!rstN)
      dmaStart[c] |-> (startState[c] && !$past(startState[c])));

    a_r3_stop_on_fall: assert property (@(posedge clk) disable iff (!rstN)
      dmaStop[c] |-> (!startState[c] && $past(startState[c])));

    a_r4_start_needs_drive: assert property (@(posedge clk) disable iff (!rstN)
      dmaStart[c] |-> $past(selPresent));

    a_r5_active_follows_high: assert property (@(posedge clk) disable iff (!rstN)
      dmaActive[c] |=> actState[c]);

    a_r5_active_follows_low: assert property (@(posedge clk) disable iff (!rstN)
      !dmaActive[c] |=> !actState[c]);

    a_r6_int_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      dmaIntEv[c] |=> intState[c]);

    a_r7_err_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      dmaErrEv[c] |=> errState[c]);

    a_r8_ptr_low_zero: assert property (@(posedge clk) disable iff (!rstN)
      ptrState[c][1:0] == 2'b00);

    a_r10_disabled_frozen: assert property (@(posedge clk) disable iff (!rstN)
      !busMasterEn |=> (!dmaStart[c] && !dmaStop[c] && $stable(ptrState[c])));
  end

endmodule

bind ide_bm_regs ide_bm_regs_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busMasterEn(busMasterEn),
  .devPresent (devPresent),
  .devSel     (devSel),
  .dmaActive  (dmaActive),
  .dmaIntEv   (dmaIntEv),
  .dmaErrEv   (dmaErrEv),
  .dmaStart   (dmaStart),
  .dmaStop    (dmaStop),
  .startState (startState),
  .intState   (intState),
  .errState   (errState),
  .actState   (actState),
  .ptrState   (ptrState)
);

// File: tb/ide_bm_regs_bench.sv
module ide_bm_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busMasterEn = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic        accSpace = 1'b0;
  logic [3:0]  accAddr = '0;
  logic [1:0]  accSize = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        accErr;
  logic [3:0]  devPresent = '0;
  logic [1:0]  dmaActive = '0;
  logic [1:0]  dmaIntEv = '0;
  logic [1:0]  dmaErrEv = '0;
  logic [1:0]  dmaStart, dmaStop, dmaDir, devSel;

  ide_bm_regs u_ide_bm_regs (
    .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn),
    .accValid(accValid), .accWrite(accWrite), .accSpace(accSpace),
    .accAddr(accAddr), .accSize(accSize), .wrData(wrData),
    .rdData(rdData), .accErr(accErr), .devPresent(devPresent),
    .dmaActive(dmaActive), .dmaIntEv(dmaIntEv), .dmaErrEv(dmaErrEv),
    .dmaStart(dmaStart), .dmaStop(dmaStop), .dmaDir(dmaDir), .devSel(devSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit          mStart[2], mDir[2], mAct[2], mInt[2], mErr[2], mSel[2];
  bit          mStartP[2], mStopP[2];
  bit          mAccErr;
  int unsigned mPtr[2];

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string curReq = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mStart[c] = 0; mDir[c] = 0; mAct[c] = 0; mInt[c] = 0;
        mErr[c] = 0; mSel[c] = 0; mStartP[c] = 0; mStopP[c] = 0; mPtr[c] = 0;
      end
      mAccErr = 0;
    end else begin
      int ch, ofs;
      bit clrInt[2], clrErr[2];
      ch = accAddr[3];
      ofs = accAddr[2:0];
      mAccErr = 0;
      for (int c = 0; c < 2; c++) begin
        mStartP[c] = 0; mStopP[c] = 0; clrInt[c] = 0; clrErr[c] = 0;
      end
      if (accValid && accWrite) begin
        if (!accSpace) begin
          if (busMasterEn) begin
            if (ofs == 0) begin
              if (accSize != 0) mAccErr = 1;
              else begin
                mDir[ch] = wrData[3];
                if (wrData[0] && !mStart[ch]) begin
                  if (devPresent[2*ch + int'(mSel[ch])]) begin
                    mStart[ch] = 1; mStartP[ch] = 1;
                  end else mAccErr = 1;
                end else if (!wrData[0] && mStart[ch]) begin
                  mStart[ch] = 0; mStopP[ch] = 1;
                end
              end
            end else if (ofs == 2) begin
              if (accSize != 0) mAccErr = 1;
              else begin
                clrInt[ch] = wrData[2];
                clrErr[ch] = wrData[1];
              end
            end else if (ofs == 4) begin
              if (accSize != 2) mAccErr = 1;
              else mPtr[ch] = wrData & 32'hFFFF_FFFC;
            end
          end
        end else begin
          if (accSize == 3) mAccErr = 1;
          else if (ofs == 6) mSel[ch] = wrData[4];
        end
      end
      for (int c = 0; c < 2; c++) begin
        mAct[c] = dmaActive[c];
        if (dmaIntEv[c]) mInt[c] = 1; else if (clrInt[c]) mInt[c] = 0;
        if (dmaErrEv[c]) mErr[c] = 1; else if (clrErr[c]) mErr[c] = 0;
      end
    end
  end

  function automatic logic [31:0] modelRead();
    int ch, ofs;
    logic [31:0] v;
    ch = accAddr[3];
    ofs = accAddr[2:0];
    v = '0;
    if (!accSpace) begin
      if (ofs == 0) begin v[0] = mStart[ch]; v[3] = mDir[ch]; end
      else if (ofs == 2) begin v[0] = mAct[ch]; v[1] = mErr[ch]; v[2] = mInt[ch]; end
      else if (ofs == 4) v = mPtr[ch];
    end else if (ofs == 6) v[4] = mSel[ch];
    return v;
  endfunction

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("rdData", rdData, modelRead());
      cmp("accErr", 32'(accErr), 32'(mAccErr));
      cmp("dmaStart", 32'(dmaStart), 32'({mStartP[1], mStartP[0]}));
      cmp("dmaStop", 32'(dmaStop), 32'({mStopP[1], mStopP[0]}));
      cmp("dmaDir", 32'(dmaDir), 32'({mDir[1], mDir[0]}));
      cmp("devSel", 32'(devSel), 32'({mSel[1], mSel[0]}));
    end
  end

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic acc(bit wr, bit sp, int addr, int sz, logic [31:0] d);
    @(posedge clk); #1;
    accValid = 1; accWrite = wr; accSpace = sp;
    accAddr = 4'(addr); accSize = 2'(sz); wrData = d;
    @(posedge clk); #1;
    accValid = 0; accWrite = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic look(bit sp, int addr);
    @(posedge clk); #1;
    accSpace = sp; accAddr = 4'(addr);
    @(posedge clk); #1;
  endtask

  task automatic pulseEv(bit isInt, int ch, bit withClr);
    @(posedge clk); #1;
    if (isInt) dmaIntEv[ch] = 1; else dmaErrEv[ch] = 1;
    if (withClr) begin
      accValid = 1; accWrite = 1; accSpace = 0;
      accAddr = 4'(ch*8 + 2); accSize = 0; wrData = 32'h6;
    end
    @(posedge clk); #1;
    dmaIntEv = 0; dmaErrEv = 0; accValid = 0; accWrite = 0;
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    #1 rstN = 1;
    foreach (accAddr[i]) ; // no-op keeps the loop style uniform
    look(0, 0); look(0, 2); look(0, 4); look(1, 6);
    look(0, 8); look(0, 12);

    devPresent = 4'b0101;
    busMasterEn = 1;

    curReq = "R2";
    acc(1, 0, 0, 1, 32'h9);
    acc(1, 0, 0, 2, 32'h1);
    look(0, 0);

    curReq = "R3";
    acc(1, 0, 0, 0, 32'h9);
    idle(2);
    acc(1, 0, 0, 0, 32'h1);
    acc(1, 0, 0, 0, 32'h0);
    acc(1, 0, 0, 0, 32'h0);
    look(0, 0);

    curReq = "R4";
    acc(1, 1, 6, 0, 32'h10);
    acc(1, 0, 0, 0, 32'h9);
    look(0, 0);

    curReq = "R9";
    acc(1, 1, 6, 3, 32'h0);
    look(1, 6);
    acc(1, 1, 6, 1, 32'h0);
    acc(1, 1, 14, 2, 32'h10);
    look(1, 14);

    curReq = "R5";
    dmaActive = 2'b01;
    look(0, 2);
    acc(1, 0, 2, 0, 32'h1);
    acc(1, 0, 2, 2, 32'h0);
    dmaActive = 2'b10;
    look(0, 10);
    dmaActive = 2'b00;

    curReq = "R6";
    pulseEv(1, 0, 0);
    look(0, 2);
    acc(1, 0, 2, 0, 32'h0);
    acc(1, 0, 2, 0, 32'h4);
    pulseEv(1, 0, 0);
    pulseEv(1, 0, 1);
    look(0, 2);

    curReq = "R7";
    pulseEv(0, 1, 0);
    look(0, 10);
    acc(1, 0, 10, 0, 32'h4);
    acc(1, 0, 10, 0, 32'h2);
    pulseEv(0, 1, 1);
    look(0, 10);

    curReq = "R8";
    acc(1, 0, 4, 2, 32'h1234_5677);
    look(0, 4);
    acc(1, 0, 4, 0, 32'hFF);
    acc(1, 0, 4, 1, 32'hFFFF);
    look(0, 4);

    curReq = "R10";
    busMasterEn = 0;
    acc(1, 0, 8, 0, 32'h1);
    acc(1, 0, 12, 2, 32'hABCD_0000);
    acc(1, 0, 0, 1, 32'h0);
    acc(1, 1, 14, 0, 32'h00);
    look(0, 12);
    busMasterEn = 1;

    curReq = "R11";
    acc(1, 0, 8, 0, 32'h1);
    acc(1, 0, 12, 2, 32'h0000_1000);
    look(0, 4);
    look(0, 0);
    look(0, 1);
    look(0, 8);

    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      busMasterEn = ($urandom_range(0, 7) != 0);
      devPresent  = 4'($urandom);
      dmaActive   = 2'($urandom);
      dmaIntEv    = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      dmaErrEv    = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      accValid    = $urandom_range(0, 1);
      accWrite    = $urandom_range(0, 1);
      accSpace    = ($urandom_range(0, 3) == 0);
      accAddr     = 4'($urandom);
      accSize     = ($urandom_range(0, 3) == 0) ? 2'($urandom) : (accAddr[2] ? 2'd2 : 2'd0);
      wrData      = $urandom;
    end
    @(posedge clk); #1;
    accValid = 0; dmaIntEv = 0; dmaErrEv = 0;
    idle(3);
    finishRun();
  end

endmodule